// File: doc/BRIEF.md
# Paged Sprite-Memory DMA Engine

This block copies one page of CPU address space into a fixed sprite-memory data port. Software starts a copy by writing a page number to a trigger address. From the next cycle the engine holds the CPU's ready line low to request a halt. The CPU only honours the request on a cycle in which it reads, so the engine keeps asking on every following cycle until a read cycle arrives. The cycle in which the halt takes hold moves no data.

Once the CPU is halted, the engine works in read/write pairs. Memory cycles alternate between a get phase, in which reading is allowed, and a put phase, in which writing is allowed. This phase is an input, because the phase of the first cycle after reset is arbitrary. The engine reads a byte only in a get phase and writes it to the sprite port in the following put phase. When it needs to read but sits in a put phase, it spends that cycle as an idle alignment cycle.

A higher-priority requester can claim any get slot. In that case the engine gives up the read and retries on the next get slot, which costs one extra alignment cycle. When the last byte has been written, the engine releases the ready line and the CPU repeats the read it was halted on.

Top module: `sprite_page_dma`

## Requirements
- R1: After reset, `cpuReady` is 1, `busy` is 0, and `dmaRd` and `dmaWr` are both 0.
- R2: A write (`cpuWrite`=1) to `TRIG_ADDR` while the engine is idle starts a transfer. From the next cycle, `cpuReady` is 0 and `busy` is 1. The halt takes hold on the first cycle with `cpuWrite`=0. Each earlier cycle with `cpuWrite`=1 is a failed attempt, and no DMA access happens on such a cycle.
- R3: The cycle in which the halt takes hold performs no access. If the next cycle is a put phase (`getPhase`=0), it becomes an alignment cycle. The first read falls on the first get phase after the halt cycle: one cycle after the halt if the halt was in a put phase, two cycles after if it was in a get phase.
- R4: The engine performs 256 pairs. The read of pair k drives `dmaAddr` = {page, k} with the 8-bit offset k running from 0x00 up to 0xFF. The write that follows it drives `dmaAddr` = `PORT_ADDR` with `dmaWdata` equal to the byte just read.
- R5: With no steals, `cpuReady` stays 0 for 513 cycles counted from the halt cycle when the halt falls in a put phase, and for 514 cycles when it falls in a get phase.
- R6: The page used is the last value written to `TRIG_ADDR` before the halt takes hold. A rewrite during a failed attempt replaces the first value.
- R7: While `stealReq` is 1 in a get phase, the engine does not read. It retries on the next get phase, and each such stolen read adds exactly 2 cycles to the halted time.
- R8: A write to `TRIG_ADDR` once the halt has taken hold is ignored. The page and the read sequence are unchanged, and no new transfer starts afterwards.
- R9: In the cycle right after the last write, `cpuReady` is 1 and `busy` is 0.

Ports (`dmaRdata`, `dmaWdata` and `cpuWdata` are 8 bits; the page number is `cpuWdata[7:0]`):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address of the current cycle |
| cpuWrite | input | 1 | 1 when the CPU is writing this cycle, 0 when it is reading |
| cpuWdata | input | 8 | CPU write data (page number on a trigger write) |
| getPhase | input | 1 | 1 = get (read) phase, 0 = put (write) phase |
| stealReq | input | 1 | Higher-priority requester claims this get slot |
| dmaRdata | input | 8 | Data returned by memory for a DMA read |
| cpuReady | output | 1 | CPU ready line, 0 while a halt is requested or in force |
| busy | output | 1 | Transfer pending or in progress |
| dmaAddr | output | 16 | DMA address |
| dmaRd | output | 1 | DMA read this cycle |
| dmaWr | output | 1 | DMA write this cycle |
| dmaWdata | output | 8 | DMA write data |

## Verification
Two events can fall in the same cycle: a stolen get slot and the read the engine wants to make in that slot. Another pair is a trigger rewrite and a failed halt attempt. The bench asserts `stealReq` on chosen get slots of a running transfer, including the very first get after the halt. It then judges the outcome by three things: no read may occur in a stolen slot, the address sequence must stay gap-free, and the halted time must grow by exactly two cycles per stolen slot. Rewrites during failed attempts are judged by the page seen on the later read addresses. Trigger writes during the halt are judged the same way.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } dmaState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPage;
    logic clearOffset;
    logic doRead;
    logic doWrite;
  } dmaStrobe_t;

endpackage

// File: rtl/sprite_dma_datapath.sv
module sprite_dma_datapath
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int COUNT_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0204
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] dmaRdata,
  output logic              lastPair,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [DATA_W-1:0] dmaWdata
);
  localparam int PAGE_W = ADDR_W - COUNT_W;

  logic [PAGE_W-1:0]  page;
  logic [COUNT_W-1:0] offset;
  logic [DATA_W-1:0]  holdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      page     <= '0;
      offset   <= '0;
      holdData <= '0;
    end else begin
      if (strobe.loadPage)    page <= cpuWdata[PAGE_W-1:0];
      if (strobe.clearOffset) offset <= '0;
      else if (strobe.doWrite) offset <= offset + 1'b1;
      if (strobe.doRead)      holdData <= dmaRdata;
    end
  end

  assign lastPair = (offset == {COUNT_W{1'b1}});
  assign dmaAddr  = strobe.doWrite ? PORT_ADDR : {page, offset};
  assign dmaWdata = holdData;

  // Each write advances the offset by exactly one (R4)
  assert_offset_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doWrite && !strobe.clearOffset) |=> (offset == $past(offset) + 1'b1));

endmodule

// File: rtl/sprite_dma_control.sv
module sprite_dma_control
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h0E14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              getPhase,
  input  logic              stealReq,
  input  logic              lastPair,
  output dmaStrobe_t        strobe,
  output logic              cpuReady,
  output logic              busy
);
  dmaState_e state, stateNext;
  logic haveData, haveDataNext;
  logic trigHit;

  assign trigHit = cpuWrite && (cpuAddr == TRIG_ADDR) && (state != ST_RUN);

  always_comb begin
    stateNext          = state;
    haveDataNext       = haveData;
    strobe             = '0;
    strobe.loadPage    = trigHit;
    case (state)
      ST_IDLE: if (trigHit) stateNext = ST_WAIT;
      ST_WAIT: if (!cpuWrite) begin
        stateNext          = ST_RUN;
        strobe.clearOffset = 1'b1;
        haveDataNext       = 1'b0;
      end
      ST_RUN: begin
        strobe.doRead  = getPhase && !stealReq && !haveData;
        strobe.doWrite = !getPhase && haveData;
        if (strobe.doRead)  haveDataNext = 1'b1;
        if (strobe.doWrite) begin
          haveDataNext = 1'b0;
          if (lastPair) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      haveData <= 1'b0;
    end else begin
      state    <= stateNext;
      haveData <= haveDataNext;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign cpuReady = (state == ST_IDLE);

  // Halt takes hold only after a CPU read cycle (R2)
  assert_halt_on_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_WAIT) |-> !$past(cpuWrite));

  // A read is never immediately followed by another read (R4)
  assert_read_pairs_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRead |=> !strobe.doRead);

  // Release comes only after a write (R9)
  assert_release_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strobe.doWrite));

endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int COUNT_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h0E14,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0204
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              getPhase,
  input  logic              stealReq,
  input  logic [DATA_W-1:0] dmaRdata,
  output logic              cpuReady,
  output logic              busy,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              dmaRd,
  output logic              dmaWr,
  output logic [DATA_W-1:0] dmaWdata
);
  dmaStrobe_t strobe;
  logic lastPair;

  sprite_dma_control #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .getPhase(getPhase), .stealReq(stealReq), .lastPair(lastPair),
    .strobe(strobe), .cpuReady(cpuReady), .busy(busy)
  );

  sprite_dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
                        .PORT_ADDR(PORT_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWdata(cpuWdata),
    .dmaRdata(dmaRdata), .lastPair(lastPair), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata)
  );

  assign dmaRd = strobe.doRead;
  assign dmaWr = strobe.doWrite;

  // Any DMA access happens only with the CPU held (R2)
  assert_halted_during_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRd || dmaWr) |-> !cpuReady);

  // Writes target the sprite port (R4)
  assert_write_port_R4: assert property (@(posedge clk) disable iff (!rstN)
    dmaWr |-> (dmaAddr == PORT_ADDR));

  // No read in a put phase or a stolen slot (R3, R7)
  assert_read_slot_R7: assert property (@(posedge clk) disable iff (!rstN)
    dmaRd |-> (getPhase && !stealReq));

endmodule

// File: tb/sprite_page_dma_tb.sv
module sprite_page_dma_tb;
  localparam logic [15:0] TRIG = 16'h0E14;
  localparam logic [15:0] PORT = 16'h0204;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuWrite = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic getPhase = 1'b0;
  logic stealReq = 1'b0;
  logic [7:0] dmaRdata;
  logic cpuReady, busy, dmaRd, dmaWr;
  logic [15:0] dmaAddr;
  logic [7:0] dmaWdata;

  int testsRun = 0;
  int testsFailed = 0;
  logic phaseNext = 1'b1;

  always #10 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign dmaRdata = memByte(dmaAddr);

  sprite_page_dma u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .getPhase(getPhase), .stealReq(stealReq),
    .dmaRdata(dmaRdata), .cpuReady(cpuReady), .busy(busy), .dmaAddr(dmaAddr),
    .dmaRd(dmaRd), .dmaWr(dmaWr), .dmaWdata(dmaWdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then let outputs settle
  task automatic tick(input logic wr, input logic [15:0] a, input logic [7:0] d,
                      input logic st);
    @(negedge clk);
    cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    getPhase = phaseNext; stealReq = st && phaseNext;
    phaseNext = ~phaseNext;
    #1;
  endtask

  task automatic runXfer(input string name, input logic [7:0] page,
                         input logic [7:0] page2, input int nFail,
                         input bit haltOnGet, input int stealMod,
                         input bit trigWhileHalted);
    logic [7:0] expPage;
    int cyc, reads, writes, steals, firstRead;
    bit lastWasWrite, sawStrobeEarly;
    expPage = page;
    if ((phaseNext ^ logic'((1 + nFail) % 2)) != haltOnGet)
      tick(1'b0, 16'h8000, 8'h00, 1'b0);
    // trigger cycle
    tick(1'b1, TRIG, page, 1'b0);
    chk(cpuReady && !busy, {name, " R2 ready before trigger edge"}, cpuReady, 1);
    sawStrobeEarly = 0;
    for (int i = 0; i < nFail; i++) begin
      if (i == 0 && page2 != page) begin
        tick(1'b1, TRIG, page2, 1'b0);
        expPage = page2;
      end else
        tick(1'b1, 16'h0300, 8'hEE, 1'b0);
      chk(!cpuReady && busy, {name, " R2 halt requested on failed attempt"}, cpuReady, 0);
      if (dmaRd || dmaWr) sawStrobeEarly = 1;
    end
    chk(!sawStrobeEarly, {name, " R2 no access on failed attempts"}, sawStrobeEarly, 0);
    // halt cycle (CPU read)
    tick(1'b0, 16'h8123, 8'h00, 1'b0);
    chk(getPhase == haltOnGet, {name, " halt phase setup"}, getPhase, haltOnGet);
    chk(!cpuReady && !dmaRd && !dmaWr, {name, " R3 halt cycle idle"}, {dmaRd, dmaWr}, 0);
    cyc = 1; reads = 0; writes = 0; steals = 0; firstRead = -1; lastWasWrite = 0;
    while (cyc < 2000) begin
      tick(trigWhileHalted && cyc == 20, (trigWhileHalted && cyc == 20) ? TRIG : 16'h8123,
           ~page, stealMod != 0 && (cyc % stealMod) == 1);
      if (cpuReady) break;
      cyc++;
      if (stealReq) steals++;
      if (dmaRd) begin
        if (firstRead < 0) firstRead = cyc - 1;
        if (!getPhase || stealReq)
          chk(0, {name, " R7 read in forbidden slot"}, {getPhase, stealReq}, 2);
        if (dmaAddr != {expPage, reads[7:0]})
          chk(0, {name, " R4/R6 read address"}, dmaAddr, {expPage, reads[7:0]});
        reads++;
        lastWasWrite = 0;
      end else if (dmaWr) begin
        if (dmaAddr != PORT || dmaWdata != memByte({expPage, writes[7:0]}))
          chk(0, {name, " R4 write addr/data"}, dmaWdata, memByte({expPage, writes[7:0]}));
        writes++;
        lastWasWrite = 1;
      end
    end
    chk(reads == 256, {name, " R4 read count"}, reads, 256);
    chk(writes == 256, {name, " R4 write count"}, writes, 256);
    chk(lastWasWrite, {name, " R9 last access was write"}, lastWasWrite, 1);
    chk(cpuReady && !busy, {name, " R9 released"}, busy, 0);
    if (stealMod == 0)
      chk(firstRead == (haltOnGet ? 2 : 1), {name, " R3 first read position"},
          firstRead, haltOnGet ? 2 : 1);
    chk(cyc == 513 + int'(haltOnGet) + 2 * steals, {name, " R5/R7 halted cycles"},
        cyc, 513 + int'(haltOnGet) + 2 * steals);
    // idle afterwards: no restart (R8)
    tick(1'b0, 16'h8123, 8'h00, 1'b0);
    tick(1'b0, 16'h8124, 8'h00, 1'b0);
    chk(cpuReady && !busy && !dmaRd && !dmaWr, {name, " R8 stays idle after transfer"},
        busy, 0);
  endtask

  task automatic testReset();
    chk(cpuReady == 1, "R1 reset cpuReady", cpuReady, 1);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(!dmaRd && !dmaWr, "R1 reset strobes", {dmaRd, dmaWr}, 0);
  endtask

  initial begin
    #5;
    testReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    tick(1'b1, 16'h0E15, 8'h33, 1'b0);
    tick(1'b0, 16'h8000, 8'h00, 1'b0);
    chk(cpuReady && !busy, "R2 other address does not trigger", busy, 0);
    runXfer("putHalt", 8'h12, 8'h12, 0, 1'b0, 0, 1'b0);
    runXfer("getHaltRetry", 8'h34, 8'h34, 2, 1'b1, 0, 1'b0);
    runXfer("rewrite", 8'h56, 8'hA7, 1, 1'b0, 0, 1'b0);
    runXfer("steals", 8'h78, 8'h78, 0, 1'b0, 9, 1'b0);
    runXfer("stealsGet", 8'h9B, 8'h9B, 3, 1'b1, 14, 1'b0);
    runXfer("ignoreTrig", 8'hC1, 8'hC1, 0, 1'b1, 0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 200000);
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule